// File: doc/BRIEF.md
# Latched Serial-In LED Sink Controller

This block is the digital control path of a cascadable LED sink driver. Serial bits enter a shift chain one stage per rising clock edge. The last stage is driven out on a serial output so a second device can take the bits that fall off the end. A bank of level-sensitive latches makes a parallel copy of the chain. One sink-enable output per channel then drives an external constant-current sink. The analog current regulation lies outside this block.

The latches are transparent while the latch-enable input is high and hold while it is low. An active-low output enable blanks every sink output and leaves the stored latch contents untouched. An undervoltage flag also forces every sink off. If the latch enable is tied high, the latches pass the chain straight through. In that case the output enable must stay high during loading so that rippling bits never reach the sinks. In silicon the latch enable has a pull-down and the output enable has a pull-up, so the safe defaults are hold and blanked. Here the control inputs are assumed to be synchronous to the shift clock.

Top module: `led_sink_front`

## Requirements
- R1: When `rst_n` is low at a rising clock edge, every chain stage and every latch becomes 0, so `sink_on` reads all zeros.
- R2: At each rising edge with `rst_n` high, stage 0 of `shift_state` takes `ser_in`, and stage i (i = 1..15) takes the earlier value of stage i-1.
- R3: `ser_out` always equals stage 15 of the chain.
- R4: While `latch_en` is high, `latch_state` equals `shift_state` in the same cycle (the latches are transparent).
- R5: While `latch_en` is low, `latch_state` keeps the value it had when `latch_en` was last high.
- R6: While `out_en_n` is high, all 16 bits of `sink_on` are 0.
- R7: While `out_en_n` is low and `supply_low` is low, bit i of `sink_on` equals latch bit i, and a 1 turns that sink on.
- R8: Neither `out_en_n` nor `supply_low` ever changes `latch_state`.
- R9: While `supply_low` is high, all 16 bits of `sink_on` are 0, whatever `out_en_n` is.
- R10: When two devices are chained through `ser_out`, the second device's stage i holds the bit the first device held in stage 15 exactly i+1 edges earlier. 32 edges therefore fill both devices.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Shift clock; everything is updated on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_in | input | 1 | Serial data into chain stage 0 |
| latch_en | input | 1 | High: latches follow the chain; low: latches hold |
| out_en_n | input | 1 | Low: sinks follow the latches; high: all sinks blanked |
| supply_low | input | 1 | Undervoltage flag; high forces all sinks off |
| sink_on | output | 16 | Per-channel sink enable, 1 = sink on |
| ser_out | output | 1 | Last chain stage, feeds the next device |
| shift_state | output | 16 | Chain contents, bit i = stage i |
| latch_state | output | 16 | Latch contents as seen by the sinks |

## Verification
The hardest case to reach is a latch bank that holds an old pattern while the chain keeps moving and the output enable and undervoltage flag toggle underneath it. The check there is that the sinks show the held pattern, not the chain, and that blanking loses nothing. The bench loads a pattern, pulses `latch_en`, and then shifts new bits in while toggling both gating inputs. The bypass mode and a 32-bit two-device cascade are driven the same way, followed by a long random stretch. Every cycle is compared against a bit-queue model.

// File: rtl/led_sink_pkg.sv
// Package: shared types and constants for the LED sink controller.
// Assumes: nothing; included first in compile order.
package led_sink_pkg;

    // Default channel count of one device.
    localparam int unsigned LS_CHANNELS = 16;

    // Drive state chosen by the output gate.
    typedef enum logic {
        DRIVE_LIVE  = 1'b0,
        DRIVE_BLANK = 1'b1
    } drive_mode_e;

endpackage

// File: rtl/sink_shift_chain.sv
// Module: sink_shift_chain
// Serial-in shift chain. Stage 0 takes ser_in on every rising edge and each
// other stage takes its lower neighbour. The last stage drives ser_out.
// Assumes: N >= 2, synchronous active-low reset.
module sink_shift_chain #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    output logic [N-1:0] stage_q,
    output logic [N-1:0] stage_d,
    output logic         ser_out
);

    localparam int unsigned LAST = N - 1;

    generate
        for (genvar i = 0; i < N; i++) begin : g_stage
            // Next value of stage i: the serial input for stage 0, else the lower stage.
            if (i == 0) begin : g_head
                assign stage_d[i] = ser_in;
            end else begin : g_body
                assign stage_d[i] = stage_q[i-1];
            end

            // Register stage i, cleared by reset.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    stage_q[i] <= 1'b0;
                end else begin
                    stage_q[i] <= stage_d[i];
                end
            end
        end
    endgenerate

    // The last stage feeds the next device in the chain.
    assign ser_out = stage_q[LAST];

    // R2: the head stage captures the serial input of the previous cycle.
    p_head_capture_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stage_q[0] == $past(ser_in));

    // R2: the tail stage moves up from the stage below it.
    p_tail_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> stage_q[LAST] == $past(stage_q[LAST-1]));

endmodule

// File: rtl/sink_latch_bank.sv
// Module: sink_latch_bank
// Level-sensitive latch bank built from flops. While latch_en is high each
// bit passes its chain stage straight through, and the flop tracks the
// stage's next value. While latch_en is low the flop value is shown.
// Assumes: latch_en is synchronous to clk and holds steady across each edge.
module sink_latch_bank #(
    parameter int unsigned N = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         latch_en,
    input  logic [N-1:0] stage_q,
    input  logic [N-1:0] stage_d,
    output logic [N-1:0] latch_q
);

    logic [N-1:0] hold_q;

    generate
        for (genvar i = 0; i < N; i++) begin : g_cell
            // Track the stage's next value while transparent, otherwise keep it.
            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    hold_q[i] <= 1'b0;
                end else if (latch_en) begin
                    hold_q[i] <= stage_d[i];
                end
            end

            // Transparent pass-through or held value.
            assign latch_q[i] = latch_en ? stage_q[i] : hold_q[i];
        end
    endgenerate

    // R5: with the latches closed, the visible value does not move.
    p_hold_closed_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_en |=> (latch_en || latch_q == $past(latch_q)));

endmodule

// File: rtl/sink_output_gate.sv
// Module: sink_output_gate
// Output gate. Blanks all sink enables when the active-low output enable is
// high or the undervoltage flag is set; otherwise passes the latch bits.
// Assumes: purely combinational; it never feeds back into the latches.
module sink_output_gate
    import led_sink_pkg::*;
#(
    parameter int unsigned N = 16
) (
    input  logic         out_en_n,
    input  logic         supply_low,
    input  logic [N-1:0] latch_q,
    output logic [N-1:0] sink_on
);

    drive_mode_e mode;

    // Choose the drive mode from the two blanking sources.
    always_comb begin
        mode = (out_en_n || supply_low) ? DRIVE_BLANK : DRIVE_LIVE;
    end

    generate
        for (genvar i = 0; i < N; i++) begin : g_sink
            // Each channel turns on only in live mode with its latch set.
            assign sink_on[i] = (mode == DRIVE_LIVE) && latch_q[i];
        end
    endgenerate

endmodule

// File: rtl/led_sink_front.sv
// Module: led_sink_front (top)
// Cascadable serial-in, latched LED sink controller: shift chain, latch bank
// and output gate. Outputs are per-channel sink enables plus the serial
// output for chaining.
// Assumes: all control inputs are synchronous to clk; synchronous active-low reset.
module led_sink_front
    import led_sink_pkg::*;
#(
    parameter int unsigned N = LS_CHANNELS
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         ser_in,
    input  logic         latch_en,
    input  logic         out_en_n,
    input  logic         supply_low,
    output logic [N-1:0] sink_on,
    output logic         ser_out,
    output logic [N-1:0] shift_state,
    output logic [N-1:0] latch_state
);

    logic [N-1:0] stage_d;

    sink_shift_chain #(.N(N)) u_chain (
        .clk     (clk),
        .rst_n   (rst_n),
        .ser_in  (ser_in),
        .stage_q (shift_state),
        .stage_d (stage_d),
        .ser_out (ser_out)
    );

    sink_latch_bank #(.N(N)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .latch_en (latch_en),
        .stage_q  (shift_state),
        .stage_d  (stage_d),
        .latch_q  (latch_state)
    );

    sink_output_gate #(.N(N)) u_gate (
        .out_en_n   (out_en_n),
        .supply_low (supply_low),
        .latch_q    (latch_state),
        .sink_on    (sink_on)
    );

    // R1: a reset edge leaves chain and latches empty.
    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (shift_state == '0 && (latch_en || latch_state == '0)));

    // R3: the serial output is the last chain stage.
    p_serout_last_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ser_out == shift_state[N-1]);

    // R4: an open latch shows the chain in the same cycle.
    p_transparent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        latch_en |-> latch_state == shift_state);

    // R6: output enable high blanks every sink.
    p_blank_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_en_n |-> sink_on == '0);

    // R7: when enabled and powered, the sinks follow the latches.
    p_follow_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_en_n && !supply_low) |-> sink_on == latch_state);

    // R9: undervoltage forces every sink off.
    p_uvlo_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        supply_low |-> sink_on == '0);

endmodule

// File: tb/tb_led_sink_front.sv
// Bench: two chained devices against a bit-queue reference model.
// Inputs change at the falling edge and outputs are compared 1 ns later.
module tb_led_sink_front;

    localparam int CH = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_in = 1'b0;
    logic latch_en = 1'b0;
    logic out_en_n = 1'b1;
    logic supply_low = 1'b0;

    logic [CH-1:0] sink_a, shift_a, latch_a;
    logic [CH-1:0] sink_b, shift_b, latch_b;
    logic          sout_a, sout_b;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    // Model state: 32-entry bit queue (index 0 = first device stage 0).
    bit           chain[$];
    bit [CH-1:0]  hold_a = '0;
    bit [CH-1:0]  hold_b = '0;
    bit           prev_rst = 1'b1;

    always #10 clk = ~clk;

    led_sink_front #(.N(CH)) dut (
        .clk(clk), .rst_n(rst_n), .ser_in(ser_in), .latch_en(latch_en),
        .out_en_n(out_en_n), .supply_low(supply_low),
        .sink_on(sink_a), .ser_out(sout_a), .shift_state(shift_a), .latch_state(latch_a)
    );

    led_sink_front #(.N(CH)) dut_nxt (
        .clk(clk), .rst_n(rst_n), .ser_in(sout_a), .latch_en(latch_en),
        .out_en_n(out_en_n), .supply_low(supply_low),
        .sink_on(sink_b), .ser_out(sout_b), .shift_state(shift_b), .latch_state(latch_b)
    );

    function automatic bit [CH-1:0] pack(input int base);
        bit [CH-1:0] v;
        for (int i = 0; i < CH; i++) v[i] = chain[base + i];
        return v;
    endfunction

    task automatic chk(input string tag, input logic [CH-1:0] got, input logic [CH-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h at %0t", tag, got, exp, $time);
        end
    endtask

    task automatic compare();
        bit [CH-1:0] sa, sb, la, lb;
        string ltag, stag;
        sa = pack(0);
        sb = pack(CH);
        la = latch_en ? sa : hold_a;
        lb = latch_en ? sb : hold_b;
        ltag = latch_en ? "R4" : "R5 R8";
        stag = out_en_n ? "R6" : (supply_low ? "R9" : "R7");
        if (!prev_rst) begin
            chk("R1 shift", shift_a, '0);
            chk("R1 latch", latch_a, '0);
            chk("R1 sink", sink_a, '0);
        end
        chk("R2 shift", shift_a, sa);
        chk("R3 ser_out", {15'd0, sout_a}, {15'd0, sa[CH-1]});
        chk({ltag, " latch"}, latch_a, la);
        chk({stag, " sink"}, sink_a, (out_en_n || supply_low) ? '0 : la);
        chk("R10 cascade shift", shift_b, sb);
        chk("R10 cascade ser_out", {15'd0, sout_b}, {15'd0, sb[CH-1]});
        chk({"R10 ", ltag, " cascade latch"}, latch_b, lb);
        chk({"R10 ", stag, " cascade sink"}, sink_b, (out_en_n || supply_low) ? '0 : lb);
    endtask

    // One cycle: drive, compare, then advance the model at the rising edge.
    task automatic step(input bit r, input bit s, input bit le, input bit oe, input bit uv);
        @(negedge clk);
        rst_n = r; ser_in = s; latch_en = le; out_en_n = oe; supply_low = uv;
        #1;
        compare();
        @(posedge clk);
        prev_rst = r;
        if (!r) begin
            foreach (chain[i]) chain[i] = 1'b0;
            hold_a = '0;
            hold_b = '0;
        end else begin
            chain.push_front(s);
            void'(chain.pop_back());
            if (le) begin
                hold_a = pack(0);
                hold_b = pack(CH);
            end
        end
    endtask

    // Shift a word in, bit 15 first, with fixed controls.
    task automatic load(input logic [CH-1:0] w, input bit le, input bit oe, input bit uv);
        for (int i = CH - 1; i >= 0; i--) step(1'b1, w[i], le, oe, uv);
    endtask

    initial begin
        for (int i = 0; i < 2 * CH; i++) chain.push_back(1'b0);
        repeat (2) @(posedge clk);
        // R1: reset cycles, then the empty state.
        step(1'b0, 1'b1, 1'b0, 1'b1, 1'b0);
        step(1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R2 R5 R6: load while blanked, latches closed.
        load(16'hA5C3, 1'b0, 1'b1, 1'b0);
        // R4: open the latches for one cycle, then R7 outputs live.
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R5 R8: keep shifting with the latches closed, toggle blanking and undervoltage.
        for (int k = 0; k < 12; k++) step(1'b1, k[0], 1'b0, k[1], k[2]);
        // R9: undervoltage while enabled.
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b1);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // Patterns: all ones and a single bit.
        load(16'hFFFF, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        load(16'h0001, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        // R4 bypass: latches open, outputs blanked while loading, then enabled.
        load(16'h3C96, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b0, 1'b0);
        // R10: 32-bit cascade fill, then latch both devices and show.
        load(16'h1234, 1'b0, 1'b1, 1'b0);
        load(16'hFEDC, 1'b0, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b1, 1'b1, 1'b0);
        step(1'b1, 1'b0, 1'b0, 1'b0, 1'b0);
        // R1: reset in the middle of a run.
        step(1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        step(1'b1, 1'b1, 1'b0, 1'b0, 1'b0);
        // Random stretch.
        for (int k = 0; k < 400; k++)
            step(1'b1, 1'($urandom % 2), ($urandom % 4) == 0, 1'($urandom % 2), ($urandom % 8) == 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    // Watchdog: a hung run counts as a failed check.
    initial begin
        #(20 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

endmodule